// File: doc/BRIEF.md
# Interrupt and Pause Controller

This block collects level-sensitive interrupt requests from up to 32 normal sources and one separate fast source, and presents them to a processor on two request lines, `irq` and `fiq`. Software enables or disables each source with dedicated set and clear registers and reads back the raw levels and the masked status. All registers sit at word offsets from one base address on a simple register bus with single-cycle writes and a one-cycle read latency.

The block also carries a low-power pause control. A write to the pause register drops the clock-enable output `clkEn`. Any enabled interrupt, normal or fast, raises it again. An identification word, a reset-status register with write-one-to-set and write-one-to-clear access, and a boot-remap flag that software can clear complete the block.

Register word offsets (byte address = 4 × index; the two low address bits must be zero): 0 raw status, 1 masked status, 2 enable read and set, 3 enable clear, 4 fast control and set, 5 fast clear, 6 pause, 7 identification, 8 reset status read and set, 9 reset status clear, 10 remap clear.

Top module: `intr_pause_ctrl`

## Requirements
- R1: After reset `irq`=0, `fiq`=0, `clkEn`=1 and `remapActive`=1. The enable register (index 2) reads 0, the pause register (index 6) reads 0 and the reset-status register (index 8) reads 0x1, where bit 0 is the power-on flag.
- R2: The sources are level-sensitive. Index 0 reads the levels of `srcIn` sampled one clock earlier. When a source falls, its raw bit and its contribution to `irq` clear one cycle later, with nothing latched.
- R3: A write to index 2 sets each enable bit whose data bit is 1. A write to index 3 clears each enable bit whose data bit is 1. Data bits that are 0 leave the enable bits unchanged.
- R4: Index 1 reads raw AND enable. `irq` is 1 exactly when that value is nonzero.
- R5: `fiq` is 1 when the sampled `fastSrc` is 1 and the fast enable is set. A write with bit 0 = 1 sets the fast enable at index 4 and clears it at index 5. Index 4 reads bit 0 = sampled fast level, bit 1 = fast enable, bit 2 = `fiq`.
- R6: A write of any data to index 6 while neither `irq` nor `fiq` is 1 drives `clkEn` to 0 from the next cycle. Index 6 then reads bit 0 = 1.
- R7: While paused, `clkEn` returns to 1 one cycle after `irq` or `fiq` becomes 1. A source that is active but disabled does not end the pause.
- R8: A pause write made while `irq` or `fiq` is 1 has no effect, and `clkEn` stays 1.
- R9: Index 7 reads the constant parameter `ID_VALUE`.
- R10: Writes of 1-bits to index 8 set the matching reset-status bits, and writes of 1-bits to index 9 clear them. Any write to index 10 drives `remapActive` to 0.
- R11: Read data appears on `busRdata` one cycle after the read. An unmapped index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset from the base address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the read |
| srcIn | input | NUM_SRC | Normal interrupt request levels |
| fastSrc | input | 1 | Fast interrupt request level |
| irq | output | 1 | Normal interrupt request to the processor |
| fiq | output | 1 | Fast interrupt request to the processor |
| clkEn | output | 1 | Clock enable, 0 while paused |
| remapActive | output | 1 | Boot remap flag, cleared by software |

## Verification
The hardest situation to reach from the ports is the one-cycle gap between an enabled interrupt appearing and the clock enable returning. The same is true of its contrast case, where a disabled source is active while paused. The stimulus enters pause with one source enabled, raises a different, disabled source and holds it for several cycles. It then raises the enabled source and samples `clkEn` on both sides of the single cycle in which `irq` is already high but the pause has not yet ended. A second pass ends the pause through the fast path, and a third issues the pause write while a request is pending.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Word indices of the register map (byte offset = 4 * index)
  localparam int IDX_RAW     = 0;
  localparam int IDX_MASKED  = 1;
  localparam int IDX_ENSET   = 2;
  localparam int IDX_ENCLR   = 3;
  localparam int IDX_FASTSET = 4;
  localparam int IDX_FASTCLR = 5;
  localparam int IDX_PAUSE   = 6;
  localparam int IDX_ID      = 7;
  localparam int IDX_RSTSET  = 8;
  localparam int IDX_RSTCLR  = 9;
  localparam int IDX_REMAP   = 10;

  localparam int DATA_W = 32;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setFast;
    logic clrFast;
    logic enterPause;
    logic setRst;
    logic clrRst;
    logic clrRemap;
    logic rdStrobe;
  } ctrlStrobes_t;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  logic              wrHit;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrHit   = busSel && busWr && aligned;

  always_comb begin
    strobes            = '0;
    strobes.rdStrobe   = busSel && !busWr;
    strobes.setEn      = wrHit && (wordIdx == WORD_W'(IDX_ENSET));
    strobes.clrEn      = wrHit && (wordIdx == WORD_W'(IDX_ENCLR));
    strobes.setFast    = wrHit && (wordIdx == WORD_W'(IDX_FASTSET));
    strobes.clrFast    = wrHit && (wordIdx == WORD_W'(IDX_FASTCLR));
    strobes.enterPause = wrHit && (wordIdx == WORD_W'(IDX_PAUSE));
    strobes.setRst     = wrHit && (wordIdx == WORD_W'(IDX_RSTSET));
    strobes.clrRst     = wrHit && (wordIdx == WORD_W'(IDX_RSTCLR));
    strobes.clrRemap   = wrHit && (wordIdx == WORD_W'(IDX_REMAP));
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          ADDR_W   = 8,
  parameter int          RST_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A7C_0301
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               fastSrc,
  output logic               irq,
  output logic               fiq,
  output logic               clkEn,
  output logic               remapActive,
  output logic [NUM_SRC-1:0] enMask
);
  localparam int         WORD_W  = ADDR_W - 2;
  localparam logic [RST_W-1:0] RST_POR = RST_W'(1);

  logic [NUM_SRC-1:0] rawQ;
  logic [NUM_SRC-1:0] enQ;
  logic               fastQ, fastEnQ, pausedQ, remapQ;
  logic [RST_W-1:0]   rstQ;
  logic [DATA_W-1:0]  rdataQ, rdNext;
  logic               maskedAny, fastAct, wake;

  // Level sampling of all sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= '0;
      fastQ <= 1'b0;
    end else begin
      rawQ  <= srcIn;
      fastQ <= fastSrc;
    end
  end

  // Per-source enable bits, write-one-to-set / write-one-to-clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        enQ[i] <= 1'b0;
      else if (strobes.setEn && busWdata[i])
        enQ[i] <= 1'b1;
      else if (strobes.clrEn && busWdata[i])
        enQ[i] <= 1'b0;
    end
  end

  assign maskedAny = |(rawQ & enQ);
  assign fastAct   = fastQ & fastEnQ;
  assign wake      = maskedAny | fastAct;

  // Fast enable, pause, reset status, remap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastEnQ <= 1'b0;
      pausedQ <= 1'b0;
      rstQ    <= RST_POR;
      remapQ  <= 1'b1;
    end else begin
      if (strobes.setFast && busWdata[0])      fastEnQ <= 1'b1;
      else if (strobes.clrFast && busWdata[0]) fastEnQ <= 1'b0;

      if (wake)                    pausedQ <= 1'b0;
      else if (strobes.enterPause) pausedQ <= 1'b1;

      if (strobes.setRst)      rstQ <= rstQ | busWdata[RST_W-1:0];
      else if (strobes.clrRst) rstQ <= rstQ & ~busWdata[RST_W-1:0];

      if (strobes.clrRemap) remapQ <= 1'b0;
    end
  end

  // Read mux
  always_comb begin
    rdNext = '0;
    unique case (busAddr[ADDR_W-1:2])
      WORD_W'(IDX_RAW):     rdNext[NUM_SRC-1:0] = rawQ;
      WORD_W'(IDX_MASKED):  rdNext[NUM_SRC-1:0] = rawQ & enQ;
      WORD_W'(IDX_ENSET):   rdNext[NUM_SRC-1:0] = enQ;
      WORD_W'(IDX_FASTSET): rdNext[2:0] = {fastAct, fastEnQ, fastQ};
      WORD_W'(IDX_PAUSE):   rdNext[0] = pausedQ;
      WORD_W'(IDX_ID):      rdNext = ID_VALUE;
      WORD_W'(IDX_RSTSET):  rdNext[RST_W-1:0] = rstQ;
      default:              rdNext = '0;
    endcase
    if (busAddr[1:0] != 2'b00) rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rdataQ <= '0;
    else if (strobes.rdStrobe) rdataQ <= rdNext;
  end

  assign busRdata    = rdataQ;
  assign irq         = maskedAny;
  assign fiq         = fastAct;
  assign clkEn       = !pausedQ;
  assign remapActive = remapQ;
  assign enMask      = enQ;
endmodule

// File: rtl/intr_pause_ctrl.sv
module intr_pause_ctrl
  import intc_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          ADDR_W   = 8,
  parameter int          RST_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A7C_0301
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               fastSrc,
  output logic               irq,
  output logic               fiq,
  output logic               clkEn,
  output logic               remapActive
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] enMask;

  intc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobes(strobes)
  );

  intc_datapath #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .RST_W(RST_W), .ID_VALUE(ID_VALUE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .srcIn      (srcIn),
    .fastSrc    (fastSrc),
    .irq        (irq),
    .fiq        (fiq),
    .clkEn      (clkEn),
    .remapActive(remapActive),
    .enMask     (enMask)
  );
endmodule

// File: rtl/intr_pause_checker.sv
module intr_pause_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busWdata,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               irq,
  input logic               fiq,
  input logic               clkEn,
  input logic [NUM_SRC-1:0] enState
);
  localparam int WORD_W = ADDR_W - 2;

  logic wrPause, wrEnSet;
  assign wrPause = busSel && busWr && busAddr[1:0] == 2'b00 &&
                   busAddr[ADDR_W-1:2] == WORD_W'(IDX_PAUSE);
  assign wrEnSet = busSel && busWr && busAddr[1:0] == 2'b00 &&
                   busAddr[ADDR_W-1:2] == WORD_W'(IDX_ENSET);

  // R1: leaving reset, nothing is requested and the clock runs
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (clkEn && !irq && !fiq));

  // R2: with every source low, no normal request one cycle later
  assert_level_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (srcIn == '0) |=> !irq);

  // R3: bits written as 1 to the set register are enabled afterwards
  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEnSet |=> ((enState & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0])));

  // R6: a pause write with nothing pending stops the clock enable
  assert_pause_enter_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrPause && !irq && !fiq) |=> !clkEn);

  // R7: a pending enabled request ends the pause next cycle
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && (irq || fiq)) |=> clkEn);

  // R7: with no request the pause holds
  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !irq && !fiq) |=> !clkEn);

  // R8: a pause write while a request is pending is ignored
  assert_pause_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrPause && (irq || fiq)) |=> clkEn);
endmodule

bind intr_pause_ctrl intr_pause_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .srcIn   (srcIn),
  .irq     (irq),
  .fiq     (fiq),
  .clkEn   (clkEn),
  .enState (enMask)
);

// File: tb/intr_pause_ctrl_bench.sv
module intr_pause_ctrl_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          NUM_SRC    = 32;
  localparam int          ADDR_W     = 8;
  localparam logic [31:0] ID_VAL     = 32'h1A7C_0301;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busSel = 1'b0, busWr = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic [31:0]        busWdata = '0;
  logic [31:0]        busRdata;
  logic [NUM_SRC-1:0] srcIn = '0;
  logic               fastSrc = 1'b0;
  logic               irq, fiq, clkEn, remapActive;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] value;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];
  logic     rdIssued = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_pause_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_VALUE(ID_VAL)) u_intr_pause_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn), .fastSrc(fastSrc),
    .irq(irq), .fiq(fiq), .clkEn(clkEn), .remapActive(remapActive)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per completed read
  always @(posedge clk) rdIssued <= busSel && !busWr;
  always @(negedge clk) begin
    if (rdIssued) begin
      if (expQ.size() == 0) chk("scoreboard underrun", 32'd1, 32'd0);
      else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(it.tag, busRdata, it.value);
      end
    end
  end

  task automatic wrReg(int idx, logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = ADDR_W'(idx * 4); busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rdReg(logic [ADDR_W-1:0] addr, logic [31:0] exp, string tag);
    expItem_t it;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr;
    it.value = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic setSrc(logic [NUM_SRC-1:0] v);
    @(negedge clk); srcIn = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clkEn", 32'(clkEn), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 fiq", 32'(fiq), 32'd0);
    chk("R1 remap", 32'(remapActive), 32'd1);
    rdReg(8'h08, 32'h0, "R1 enable reg");
    rdReg(8'h18, 32'h0, "R1 pause reg");
    rdReg(8'h20, 32'h1, "R1 reset status");

    // R2/R4 raw vs masked with nothing enabled
    setSrc(32'h0000_0005);
    chk("R4 irq disabled", 32'(irq), 32'd0);
    rdReg(8'h00, 32'h5, "R2 raw status");
    rdReg(8'h04, 32'h0, "R4 masked none");

    // R3 set/clear semantics
    wrReg(2, 32'h4);
    chk("R4 irq enabled", 32'(irq), 32'd1);
    rdReg(8'h08, 32'h4, "R3 enable set");
    rdReg(8'h04, 32'h4, "R4 masked");
    wrReg(2, 32'h0);
    rdReg(8'h08, 32'h4, "R3 zero set no effect");
    wrReg(3, 32'h0);
    rdReg(8'h08, 32'h4, "R3 zero clear no effect");
    wrReg(3, 32'h4);
    chk("R3 irq after clear", 32'(irq), 32'd0);
    rdReg(8'h08, 32'h0, "R3 enable clear");

    // R2 level-sensitivity on bit 31
    wrReg(2, 32'h8000_0000);
    setSrc(32'h8000_0000);
    chk("R2 irq high", 32'(irq), 32'd1);
    setSrc(32'h0);
    chk("R2 irq drops", 32'(irq), 32'd0);
    rdReg(8'h00, 32'h0, "R2 raw cleared");
    wrReg(3, 32'hFFFF_FFFF);

    // R5 fast path
    @(negedge clk); fastSrc = 1'b1;
    @(negedge clk);
    chk("R5 fiq disabled", 32'(fiq), 32'd0);
    wrReg(4, 32'h1);
    chk("R5 fiq enabled", 32'(fiq), 32'd1);
    chk("R5 irq untouched", 32'(irq), 32'd0);
    rdReg(8'h10, 32'h7, "R5 fast reg");
    wrReg(5, 32'h1);
    chk("R5 fiq cleared", 32'(fiq), 32'd0);
    rdReg(8'h10, 32'h1, "R5 fast reg cleared");
    @(negedge clk); fastSrc = 1'b0;

    // R6/R7 pause and wake via a normal source
    wrReg(2, 32'h8);
    wrReg(6, 32'h0);
    chk("R6 clkEn low", 32'(clkEn), 32'd0);
    rdReg(8'h18, 32'h1, "R6 pause reg");
    setSrc(32'h1);
    repeat (3) @(negedge clk);
    chk("R7 disabled source no wake", 32'(clkEn), 32'd0);
    @(negedge clk); srcIn = 32'h9;
    @(negedge clk);
    chk("R7 irq seen", 32'(irq), 32'd1);
    chk("R7 still paused one cycle", 32'(clkEn), 32'd0);
    @(negedge clk);
    chk("R7 woken", 32'(clkEn), 32'd1);

    // R8 pause write while irq pending
    wrReg(6, 32'h0);
    chk("R8 pause ignored", 32'(clkEn), 32'd1);
    @(negedge clk);
    chk("R8 still running", 32'(clkEn), 32'd1);
    setSrc(32'h0);

    // R7 wake through fast path
    wrReg(4, 32'h1);
    wrReg(6, 32'h0);
    chk("R6 paused again", 32'(clkEn), 32'd0);
    @(negedge clk); fastSrc = 1'b1;
    @(negedge clk);
    chk("R7 fiq seen", 32'(fiq), 32'd1);
    @(negedge clk);
    chk("R7 fast wake", 32'(clkEn), 32'd1);
    fastSrc = 1'b0;

    // R9 identification
    rdReg(8'h1C, ID_VAL, "R9 id");

    // R10 reset status and remap
    wrReg(8, 32'h6);
    rdReg(8'h20, 32'h7, "R10 reset set");
    wrReg(9, 32'h1);
    rdReg(8'h20, 32'h6, "R10 reset clear");
    wrReg(10, 32'h0);
    chk("R10 remap cleared", 32'(remapActive), 32'd0);

    // R11 unmapped and misaligned reads
    rdReg(8'h3C, 32'h0, "R11 unmapped");
    rdReg(8'h1D, 32'h0, "R11 misaligned");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 32'(expQ.size()), 32'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule